// File: doc/BRIEF.md
# Serial ADC Conversion Capture Controller

This block runs single conversion cycles on a 12-bit serial analog-to-digital converter. The converter has three wires: an active-low conversion strobe, a serial clock and a serial data line. When a start request is accepted, the block pulls the strobe low. The falling strobe freezes the converter's sample-and-hold. The block then produces a frame of exactly 16 serial clock periods, derived from the system clock by an even divider.

Twelve result bits arrive most significant bit first. They are taken on rising serial clock edges that follow a fixed number of leading clocks; clocks outside that window are ignored. At the end of the frame the strobe returns high. The code, which is binary two's complement, is presented as a sign-extended word with a one-cycle valid pulse. The strobe then stays high for a minimum acquisition time before another request can be accepted.

The delay from strobe fall to the first clock, and the clock period, are both parameters. Each is checked against its own upper bound, because the held sample decays while it waits.

Top module: `adc_conv_capture`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, conv_no is high, sclk_o is low, valid_o is low and sample_o is zero. This holds even when reset arrives in the middle of a frame.
- R2: When start_i is sampled high in idle, conv_no goes low at the next clock edge. The first rising sclk_o edge comes exactly START_DLY system cycles later (default 2), and never later than MAX_START_DLY cycles.
- R3: Within a frame, sclk_o has a period of DIV system cycles (default 4), with DIV/2 cycles high and DIV/2 cycles low. The period never exceeds MAX_SCLK_DIV cycles.
- R4: Each frame has exactly FRAME_CLKS (16) rising sclk_o edges while conv_no is low. sclk_o is low whenever conv_no is high.
- R5: sdata_i is taken on rising sclk_o edges number LEAD_CLKS+1 through LEAD_CLKS+12 (4 to 15 by default, counting from 1). The first of these becomes code bit 11 and the last becomes bit 0. The sdata_i value at every other rising edge has no effect on sample_o.
- R6: sample_o is the 12-bit two's complement code sign-extended to 16 bits. Code 0x7FF gives 0x07FF, 0x000 gives 0x0000, 0xFFF gives 0xFFFF and 0x800 gives 0xF800.
- R7: conv_no returns high DIV/2 cycles after the last falling sclk_o edge, so it is low for START_DLY+16*DIV cycles (66 by default). valid_o is high for exactly one cycle, which is the first cycle conv_no is high again. sample_o holds its value until the next valid pulse.
- R8: start_i has no effect from the cycle conv_no goes low until the acquisition time has run out. A request raised in that span is neither served nor queued.
- R9: After a frame, conv_no stays high for at least ACQ_CYC+1 cycles (7 by default). With start_i held high, consecutive frames are separated by exactly that many high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled as a level in idle |
| sdata_i | input | 1 | Serial result data from the converter |
| conv_no | output | 1 | Active-low conversion strobe |
| sclk_o | output | 1 | Serial conversion clock |
| sample_o | output | OUT_W (16) | Sign-extended signed sample |
| valid_o | output | 1 | One-cycle pulse when sample_o is updated |

## Verification
Six result codes are shifted in, each paired with a fixed level on the data line during the clocks outside the result window. The four scale points show that sign extension treats the positive and negative halves differently. The two mixed patterns expose bit reversal or a one-clock shift of the window, and a filler level that differs from the adjacent data bits shows whether clocks outside the window are ignored. Directed runs put start requests in the middle of a frame and during acquisition, hold start high to measure the gap between frames, and apply reset in the middle of a frame.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FRAME,
    ST_ACQ
  } cap_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned DIV        = 4,
  parameter int unsigned FRAME_CLKS = 16,
  localparam int unsigned IDX_W     = $clog2(FRAME_CLKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic [IDX_W-1:0] rise_idx_o,
  output logic             done_o
);

  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic             active_q;
  logic             sclk_q;
  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] cnt_q;

  // rise_o marks the edge at which sclk goes high; done_o the frame end slot
  always_comb begin
    rise_o     = 1'b0;
    rise_idx_o = '0;
    done_o     = 1'b0;
    if (launch_i) begin
      rise_o     = 1'b1;
      rise_idx_o = IDX_W'(1);
    end else if (active_q && ph_q == PH_W'(DIV - 1)) begin
      if (cnt_q == IDX_W'(FRAME_CLKS)) begin
        done_o = 1'b1;
      end else begin
        rise_o     = 1'b1;
        rise_idx_o = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      ph_q     <= '0;
      cnt_q    <= '0;
    end else if (rise_o) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b1;
      ph_q     <= '0;
      cnt_q    <= rise_idx_o;
    end else if (done_o) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      ph_q     <= '0;
      cnt_q    <= '0;
    end else if (active_q) begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == PH_W'(HALF - 1)) sclk_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;

endmodule

// File: rtl/adc_bit_shift.sv
module adc_bit_shift #(
  parameter int unsigned DATA_BITS = 12,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned LEAD_CLKS = 3,
  parameter int unsigned IDX_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sdata_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int unsigned FIRST = LEAD_CLKS + 1;
  localparam int unsigned LAST  = LEAD_CLKS + DATA_BITS;

  logic [DATA_BITS-1:0] sh_q;
  logic                 in_win;

  assign in_win = rise_i && (idx_i >= IDX_W'(FIRST)) && (idx_i <= IDX_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (in_win) sh_q <= {sh_q[DATA_BITS-2:0], sdata_i};
  end

  generate
    if (OUT_W > DATA_BITS) begin : g_sext
      assign word_o = {{(OUT_W - DATA_BITS){sh_q[DATA_BITS-1]}}, sh_q};
    end else begin : g_trunc
      assign word_o = sh_q[DATA_BITS-1 -: OUT_W];
    end
  endgenerate

endmodule

// File: rtl/adc_conv_capture.sv
module adc_conv_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned DIV           = 4,
  parameter int unsigned FRAME_CLKS    = 16,
  parameter int unsigned DATA_BITS     = 12,
  parameter int unsigned OUT_W         = 16,
  parameter int unsigned LEAD_CLKS     = 3,
  parameter int unsigned START_DLY     = 2,
  parameter int unsigned MAX_START_DLY = 8,
  parameter int unsigned MAX_SCLK_DIV  = 16,
  parameter int unsigned ACQ_CYC       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sdata_i,
  output logic             conv_no,
  output logic             sclk_o,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);

  localparam int unsigned IDX_W = $clog2(FRAME_CLKS + 1);
  localparam int unsigned DLY_W = $clog2(START_DLY + 1);
  localparam int unsigned ACQ_W = $clog2(ACQ_CYC + 1);

  cap_state_e       state_q;
  logic             conv_q;
  logic [DLY_W-1:0] dly_q;
  logic [ACQ_W-1:0] acq_q;
  logic             valid_q;
  logic [OUT_W-1:0] sample_q;

  logic             launch;
  logic             rise;
  logic [IDX_W-1:0] rise_idx;
  logic             frame_done;
  logic [OUT_W-1:0] word;

  assign launch = (state_q == ST_SETUP) && (dly_q == DLY_W'(START_DLY));

  adc_sclk_gen #(
    .DIV       (DIV),
    .FRAME_CLKS(FRAME_CLKS)
  ) u_sclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .sclk_o    (sclk_o),
    .rise_o    (rise),
    .rise_idx_o(rise_idx),
    .done_o    (frame_done)
  );

  adc_bit_shift #(
    .DATA_BITS(DATA_BITS),
    .OUT_W    (OUT_W),
    .LEAD_CLKS(LEAD_CLKS),
    .IDX_W    (IDX_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .idx_i  (rise_idx),
    .sdata_i(sdata_i),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      conv_q   <= 1'b1;
      dly_q    <= '0;
      acq_q    <= '0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SETUP;
            conv_q  <= 1'b0;
            dly_q   <= DLY_W'(1);
          end
        end
        ST_SETUP: begin
          if (launch) state_q <= ST_FRAME;
          else        dly_q   <= dly_q + 1'b1;
        end
        ST_FRAME: begin
          if (frame_done) begin
            state_q  <= ST_ACQ;
            conv_q   <= 1'b1;
            valid_q  <= 1'b1;
            sample_q <= word;
            acq_q    <= ACQ_W'(1);
          end
        end
        ST_ACQ: begin
          if (acq_q == ACQ_W'(ACQ_CYC)) state_q <= ST_IDLE;
          else                          acq_q   <= acq_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_no  = conv_q;
  assign valid_o  = valid_q;
  assign sample_o = sample_q;

endmodule

// File: rtl/adc_conv_capture_chk.sv
module adc_conv_capture_chk #(
  parameter int unsigned DIV           = 4,
  parameter int unsigned FRAME_CLKS    = 16,
  parameter int unsigned START_DLY     = 2,
  parameter int unsigned MAX_START_DLY = 8,
  parameter int unsigned MAX_SCLK_DIV  = 16,
  parameter int unsigned ACQ_CYC       = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_no,
  input logic sclk_o,
  input logic valid_o
);

  localparam int unsigned CW = 16;
  localparam logic [CW-1:0] SAT = '1;

  logic          conv_q, sclk_q, first_pend, rise_evt;
  logic [CW-1:0] since_fall, since_rise, hi_run, rises;

  assign rise_evt = sclk_o && !sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q     <= 1'b1;
      sclk_q     <= 1'b0;
      first_pend <= 1'b0;
      since_fall <= '0;
      since_rise <= '0;
      hi_run     <= SAT;
      rises      <= '0;
    end else begin
      conv_q     <= conv_no;
      sclk_q     <= sclk_o;
      since_fall <= conv_no ? '0 : ((since_fall == SAT) ? SAT : since_fall + 1'b1);
      if (!conv_no && conv_q) first_pend <= 1'b1;
      else if (rise_evt)      first_pend <= 1'b0;
      since_rise <= rise_evt ? CW'(1) : ((since_rise == SAT) ? SAT : since_rise + 1'b1);
      hi_run     <= conv_no ? ((hi_run == SAT) ? SAT : hi_run + 1'b1) : '0;
      rises      <= conv_no ? '0 : rises + CW'(rise_evt);
    end
  end

  a_r2_first_clk_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_evt && first_pend) |-> since_fall == CW'(START_DLY));

  a_r2_max_hold_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_no && first_pend) |-> since_fall <= CW'(MAX_START_DLY));

  a_r3_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_evt && !first_pend) |-> since_rise == CW'(DIV));

  a_r3_max_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_no && !first_pend && rises != '0) |-> since_rise <= CW'(MAX_SCLK_DIV));

  a_r4_no_clk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_no |-> !sclk_o);

  a_r4_rise_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_no && !conv_q) |-> rises == CW'(FRAME_CLKS));

  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r7_valid_at_strobe_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (conv_no && !conv_q));

  a_r9_acq_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_no && conv_q) |-> hi_run >= CW'(ACQ_CYC + 1));

endmodule

bind adc_conv_capture adc_conv_capture_chk #(
  .DIV          (DIV),
  .FRAME_CLKS   (FRAME_CLKS),
  .START_DLY    (START_DLY),
  .MAX_START_DLY(MAX_START_DLY),
  .MAX_SCLK_DIV (MAX_SCLK_DIV),
  .ACQ_CYC      (ACQ_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .conv_no(conv_no),
  .sclk_o (sclk_o),
  .valid_o(valid_o)
);

// File: tb/adc_conv_capture_test.sv
module adc_conv_capture_test;

  logic        clk_i   = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        start_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        conv_no;
  logic        sclk_o;
  logic [15:0] sample_o;
  logic        valid_o;

  always #5 clk_i = ~clk_i;

  adc_conv_capture uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sdata_i (sdata_i),
    .conv_no (conv_no),
    .sclk_o  (sclk_o),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );

  // {code[11:0], filler bit, expected sample[15:0]}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {12'h7FF, 1'b0, 16'h07FF},
    {12'h800, 1'b1, 16'hF800},
    {12'hFFF, 1'b0, 16'hFFFF},
    {12'h000, 1'b1, 16'h0000},
    {12'h5A3, 1'b1, 16'h05A3},
    {12'hA5C, 1'b0, 16'hFA5C}
  };

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and frame monitor, sampled away from the active edge
  logic [11:0] cur_code = '0;
  logic        cur_junk = 1'b0;
  logic        prev_conv = 1'b1, prev_sclk = 1'b0, f_valid_ok = 1'b0;
  int cyc = 0, rises = 0, since_fall = 0, f_dly = 0, f_rises = 0, f_low_len = 0;
  int hi_run = 0, f_hi_gap = 0, sclk_hi = 0, bad_hi = 0, bad_per = 0, last_rise = 0;
  int frames_done = 0, frames_started = 0, valid_cnt = 0;

  always @(negedge clk_i) begin
    cyc++;
    if (conv_no) hi_run++;
    if (valid_o) valid_cnt++;
    if (!conv_no && prev_conv) begin
      frames_started++;
      rises = 0; since_fall = 0; bad_hi = 0; bad_per = 0; sclk_hi = 0;
      f_hi_gap = hi_run;
    end else if (!conv_no) begin
      since_fall++;
    end
    if (sclk_o && !prev_sclk) begin
      rises++;
      if (rises == 1) f_dly = since_fall;
      else if (cyc - last_rise != 4) bad_per++;
      last_rise = cyc;
    end
    if (sclk_o) sclk_hi++;
    else begin
      if (prev_sclk && sclk_hi != 2) bad_hi++;
      sclk_hi = 0;
    end
    if (conv_no && !prev_conv) begin
      f_rises = rises; f_low_len = since_fall + 1; f_valid_ok = valid_o;
      hi_run = 1; frames_done++;
    end
    if (!conv_no && !sclk_o) begin
      int r;
      r = rises + 1;
      sdata_i = (r >= 4 && r <= 15) ? cur_code[15 - r] : cur_junk;
    end
    prev_conv = conv_no;
    prev_sclk = sclk_o;
  end

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames_done < target && t < 1000) begin
      @(negedge clk_i); t++;
    end
    if (frames_done < target) check(1'b0, "timeout waiting for frame", frames_done, target);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v0, s0, f0;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(conv_no == 1'b1 && sclk_o == 1'b0, "R1 reset strobe/clock", {conv_no, sclk_o}, 2'b10);
    check(valid_o == 1'b0 && sample_o == 16'h0, "R1 reset valid/sample", {valid_o, sample_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(conv_no == 1'b1 && valid_o == 1'b0, "R1 after release", {conv_no, valid_o}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      cur_code = VEC[i][28:17];
      cur_junk = VEC[i][16];
      f0 = frames_done;
      v0 = valid_cnt;
      pulse_start();
      wait_frames(f0 + 1);
      repeat (3) @(negedge clk_i);
      check(sample_o == VEC[i][15:0], "R5 R6 sample", sample_o, VEC[i][15:0]);
      check(f_dly == 2, "R2 first clock delay", f_dly, 2);
      check(f_rises == 16, "R4 rising edges per frame", f_rises, 16);
      check(bad_per == 0 && bad_hi == 0, "R3 clock period/duty", {bad_per[15:0], bad_hi[15:0]}, 0);
      check(f_low_len == 66, "R7 strobe low span", f_low_len, 66);
      check(f_valid_ok == 1'b1, "R7 valid at strobe rise", f_valid_ok, 1);
      check(valid_cnt - v0 == 1, "R7 single valid pulse", valid_cnt - v0, 1);
      repeat (8) @(negedge clk_i);
    end

    // R7 sample held between pulses
    repeat (40) @(negedge clk_i);
    check(sample_o == 16'hFA5C, "R7 sample held", sample_o, 16'hFA5C);

    // R8 requests during frame and during acquisition are dropped
    cur_code = 12'h123; cur_junk = 1'b1;
    s0 = frames_started; f0 = frames_done;
    pulse_start();
    repeat (20) @(negedge clk_i);
    pulse_start();
    wait_frames(f0 + 1);
    pulse_start();
    repeat (40) @(negedge clk_i);
    check(frames_started == s0 + 1, "R8 requests ignored", frames_started - s0, 1);
    check(conv_no == 1'b1, "R8 strobe idle afterwards", conv_no, 1);
    check(sample_o == 16'h0123, "R8 frame unaffected", sample_o, 16'h0123);

    // R9 held request: back-to-back frames separated by acquisition gap
    cur_code = 12'h9C1; cur_junk = 1'b0;
    f0 = frames_done;
    @(negedge clk_i); start_i = 1'b1;
    wait_frames(f0 + 2);
    start_i = 1'b0;
    check(f_hi_gap == 7, "R9 acquisition gap", f_hi_gap, 7);
    repeat (3) @(negedge clk_i);
    check(sample_o == 16'hF9C1, "R9 second sample", sample_o, 16'hF9C1);
    repeat (20) @(negedge clk_i);

    // R1 reset in the middle of a frame
    pulse_start();
    repeat (30) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(conv_no == 1'b1 && sclk_o == 1'b0, "R1 mid-frame reset strobe/clock", {conv_no, sclk_o}, 2'b10);
    check(valid_o == 1'b0 && sample_o == 16'h0, "R1 mid-frame reset outputs", {valid_o, sample_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(conv_no == 1'b1, "R1 idle after reset", conv_no, 1);

    cur_code = 12'h001; cur_junk = 1'b1;
    f0 = frames_done;
    pulse_start();
    wait_frames(f0 + 1);
    repeat (3) @(negedge clk_i);
    check(sample_o == 16'h0001, "R5 R1 recovery sample", sample_o, 16'h0001);
    check(f_dly == 2, "R2 recovery delay", f_dly, 2);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule